// File: doc/BRIEF.md
# Configurable Multi-Mode I/O Port

This block controls an 8-pin general-purpose port for a microcontroller. A small register file, reached over a simple synchronous read/write strobe bus, sets up each pin on its own. The settings choose whether the pin shows the MCU's output data or one bit of a latched address. They choose whether the pin drives, and whether a driven pin is push-pull or open-drain. The block drives pad control lines (`pad_out`, `pad_oe`) toward an external tri-state pad. It reads the pad level back through a two-flop synchronizer.

A pin drives when its software direction bit is set or when an external per-pin output-enable term from programmable logic is high. It floats only when both are low. Two build-time options cover reduced port variants. One removes the mode register, so the port always works as plain MCU I/O. The other implements only the low bits of the direction register.

Register offsets on `reg_addr`:

| Offset | Register | Access |
|---|---|---|
| 0 | pin level, synchronized | read only |
| 1 | output data | read/write |
| 2 | mode | read/write |
| 3 | direction | read/write |
| 4 | drive type | read/write |

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the output data, mode, direction and drive registers all read 0x00. With every external output-enable low, no pin drives (`pad_oe` = 0x00).
- R2: A register write is applied on the first rising clock edge where `reg_wr` is sampled high, and pad outputs change only after that edge. A read is combinational. While `reg_rd` is high, `reg_rdata` shows the register selected by `reg_addr` in the same cycle.
- R3: Bit i of each register controls pin i only.
- R4: For a push-pull pin, `pad_out` is bit i of the latched address when the mode bit is 1, and bit i of the output data register when the mode bit is 0.
- R5: For a push-pull pin, `pad_oe` is high exactly when the direction bit (1 = output) or `pld_oe[i]` is 1. When both are 0 the pin is an input.
- R6: When the drive bit is 1 (open-drain), `pad_out` is 0. `pad_oe` is high only when the pin is an output and its selected output value is 0. A value of 1 releases the pin.
- R7: `addr_in` is captured into the address latch on each rising edge where `addr_strobe` is high. Otherwise the latch holds its value.
- R8: Reading offset 0 returns `pad_in` as it was two rising edges earlier (two-flop synchronizer).
- R9: With HAS_MODE = 0, the mode register reads 0, ignores writes, and pins always use the output data register. Direction bits at DIR_W and above read 0, ignore writes, and never enable a pin.
- R10: Writes to offset 0 and to unused offsets 5..7 change no register. Reads of unused offsets return 0x00. `reg_rdata` is 0x00 whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | ADDR_W | register offset |
| reg_wdata | input | WIDTH | write data |
| reg_rdata | output | WIDTH | read data, combinational |
| addr_in | input | WIDTH | address bits to latch |
| addr_strobe | input | 1 | address latch enable |
| pld_oe | input | WIDTH | per-pin output-enable term from logic |
| pad_in | input | WIDTH | pad input levels (asynchronous) |
| pad_out | output | WIDTH | value to drive onto the pad |
| pad_oe | output | WIDTH | pad driver enable |

## Verification
The assertions check the pad control rules on every cycle:
- a pin that should be a push-pull output always drives;
- a pin with both direction sources low never drives;
- an open-drain pin never drives a 1;
- the driven value follows the mode bit.

They also check the one-edge write latency of the direction register, the address latch, and the two-edge synchronizer delay seen on reads.

The bench scenarios are needed to show the rest:
- the reset values;
- that writes to the pin-level register and to unused offsets are ignored;
- that unused offsets read as zero;
- the reduced variant, where the mode register is missing and the upper direction bits are missing.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;

  localparam int OFS_PIN  = 0;
  localparam int OFS_OUT  = 1;
  localparam int OFS_MODE = 2;
  localparam int OFS_DIR  = 3;
  localparam int OFS_DRV  = 4;

  // value presented to the pin before the driver type is applied
  function automatic logic pin_value(input logic mode, input logic adr_bit,
                                     input logic dat_bit);
    return mode ? adr_bit : dat_bit;
  endfunction

  // driver enable: output request, and for open drain only when pulling low
  function automatic logic pin_enable(input logic dir, input logic ext_oe,
                                      input logic od, input logic val);
    return (dir | ext_oe) & (~od | ~val);
  endfunction

  // level on the driver: an open-drain driver only ever drives 0
  function automatic logic pin_level(input logic od, input logic val);
    return val & ~od;
  endfunction

endpackage

// File: rtl/cfg_io_sync.sv
module cfg_io_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/cfg_io_regs.sv
module cfg_io_regs
  import cfg_io_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 3,
  parameter bit HAS_MODE = 1'b1,
  parameter int DIR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  mode_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  drv_q
);

  function automatic logic [WIDTH-1:0] low_mask(input int n);
    logic [WIDTH-1:0] m;
    for (int i = 0; i < WIDTH; i++) m[i] = (i < n);
    return m;
  endfunction

  localparam logic [WIDTH-1:0] DIR_MASK = low_mask(DIR_W);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(OFS_PIN);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'(OFS_DRV);

  logic wr_out, wr_mode, wr_dir, wr_drv;
  assign wr_out  = wr && (addr == A_OUT);
  assign wr_mode = wr && (addr == A_MODE);
  assign wr_dir  = wr && (addr == A_DIR);
  assign wr_drv  = wr && (addr == A_DRV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      drv_q <= '0;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_dir) dir_q <= wdata & DIR_MASK;
      if (wr_drv) drv_q <= wdata;
    end
  end

  generate
    if (HAS_MODE) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= wdata;
      end
    end else begin : g_no_mode
      assign mode_q = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == A_PIN)       rdata = pin_sync;
      else if (addr == A_OUT)  rdata = out_q;
      else if (addr == A_MODE) rdata = mode_q;
      else if (addr == A_DIR)  rdata = dir_q;
      else if (addr == A_DRV)  rdata = drv_q;
    end
  end

endmodule

// File: rtl/cfg_io_pin.sv
module cfg_io_pin
  import cfg_io_pkg::*;
(
  input  logic mode,
  input  logic dir,
  input  logic od,
  input  logic dat_bit,
  input  logic adr_bit,
  input  logic ext_oe,
  output logic pad_out,
  output logic pad_oe
);

  logic val;
  assign val     = pin_value(mode, adr_bit, dat_bit);
  assign pad_oe  = pin_enable(dir, ext_oe, od, val);
  assign pad_out = pin_level(od, val);

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 3,
  parameter bit HAS_MODE = 1'b1,
  parameter int DIR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  input  logic [WIDTH-1:0]  addr_in,
  input  logic              addr_strobe,
  input  logic [WIDTH-1:0]  pld_oe,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] out_q, mode_q, dir_q, drv_q;
  logic [WIDTH-1:0] addr_lat;

  cfg_io_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  cfg_io_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .HAS_MODE(HAS_MODE), .DIR_W(DIR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .pin_sync (pin_sync),
    .rdata    (reg_rdata),
    .out_q    (out_q),
    .mode_q   (mode_q),
    .dir_q    (dir_q),
    .drv_q    (drv_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr_lat <= '0;
    else if (addr_strobe) addr_lat <= addr_in;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      cfg_io_pin u_pin (
        .mode    (mode_q[i]),
        .dir     (dir_q[i]),
        .od      (drv_q[i]),
        .dat_bit (out_q[i]),
        .adr_bit (addr_lat[i]),
        .ext_oe  (pld_oe[i]),
        .pad_out (pad_out[i]),
        .pad_oe  (pad_oe[i])
      );
    end
  endgenerate

endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3,
  parameter int DIR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WIDTH-1:0]  reg_wdata,
  input logic [WIDTH-1:0]  reg_rdata,
  input logic [WIDTH-1:0]  addr_in,
  input logic              addr_strobe,
  input logic [WIDTH-1:0]  pld_oe,
  input logic [WIDTH-1:0]  pad_in,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  out_q,
  input logic [WIDTH-1:0]  mode_q,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  drv_q,
  input logic [WIDTH-1:0]  addr_lat
);

  logic [WIDTH-1:0] dir_keep;
  always_comb
    for (int i = 0; i < WIDTH; i++) dir_keep[i] = (i < DIR_W);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        age <= '0;
    else if (age != 2) age <= age + 2'd1;

  p_pp_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((dir_q | pld_oe) & ~drv_q & ~pad_oe) == '0));

  p_input_floats_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~(dir_q | pld_oe) & pad_oe) == '0));

  p_od_no_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_q & pad_out) == '0));

  p_mode_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ ((mode_q & addr_lat) | (~mode_q & out_q))) & ~drv_q) == '0));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(3)) |=> (dir_q == ($past(reg_wdata) & dir_keep)));

  p_addr_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> (addr_lat == $past(addr_in)));

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2 && reg_rd && reg_addr == ADDR_W'(0)) |-> (reg_rdata == $past(pad_in, 2)));

endmodule

bind cfg_io_port cfg_io_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_W(DIR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_in(addr_in),
  .addr_strobe(addr_strobe), .pld_oe(pld_oe), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .out_q(out_q), .mode_q(mode_q), .dir_q(dir_q), .drv_q(drv_q),
  .addr_lat(addr_lat)
);

// File: tb/cfg_io_port_tb.sv
module cfg_io_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, addr_in = '0, pld_oe = '0, pad_in = '0;
  logic       addr_strobe = 1'b0;
  logic [7:0] rdata_a, pad_out_a, pad_oe_a;
  logic [7:0] rdata_b, pad_out_b, pad_oe_b;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_io_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .addr_in(addr_in),
    .addr_strobe(addr_strobe), .pld_oe(pld_oe), .pad_in(pad_in),
    .pad_out(pad_out_a), .pad_oe(pad_oe_a)
  );

  cfg_io_port #(.HAS_MODE(1'b0), .DIR_W(3)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .addr_in(addr_in),
    .addr_strobe(addr_strobe), .pld_oe(pld_oe), .pad_in(pad_in),
    .pad_out(pad_out_b), .pad_oe(pad_oe_b)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] da, output logic [7:0] db);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    da = rdata_a; db = rdata_b;
    reg_rd = 1'b0;
  endtask

  task automatic latch_addr(input logic [7:0] v);
    @(negedge clk);
    addr_in = v; addr_strobe = 1'b1;
    @(negedge clk);
    addr_strobe = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] a, b;
    for (int r = 1; r <= 4; r++) begin
      bus_read(3'(r), a, b);
      check("R1 reset reg", a, 8'h00);
    end
    #1 check("R1 pad_oe idle", pad_oe_a, 8'h00);
  endtask

  task automatic t_write_timing;
    logic [7:0] a, b;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'hA5;
    #1 check("R2 before edge", pad_oe_a, 8'h00);
    @(negedge clk);
    reg_wr = 1'b0;
    check("R2 after edge", pad_oe_a, 8'hA5);
    bus_read(3'd3, a, b);
    check("R2 read back dir", a, 8'hA5);
    check("R3 per-bit pad_oe", pad_oe_a, 8'hA5);
    bus_write(3'd3, 8'h00);
  endtask

  task automatic t_mode;
    bus_write(3'd1, 8'h0F);
    latch_addr(8'h3C);
    bus_write(3'd2, 8'hF0);
    bus_write(3'd3, 8'hFF);
    #1 check("R4 mixed mode pad_out", pad_out_a, 8'h3F);
    check("R7 latched addr shows", pad_out_a & 8'hF0, 8'h30);
    @(negedge clk) addr_in = 8'hFF;
    #1 check("R7 hold without strobe", pad_out_a, 8'h3F);
    bus_write(3'd2, 8'h00);
    #1 check("R4 data mode pad_out", pad_out_a, 8'h0F);
    bus_write(3'd3, 8'h00);
  endtask

  task automatic t_ext_oe;
    @(negedge clk) pld_oe = 8'h81;
    #1 check("R5 ext oe only", pad_oe_a, 8'h81);
    bus_write(3'd3, 8'h03);
    #1 check("R5 ext oe or dir", pad_oe_a, 8'h83);
    @(negedge clk) pld_oe = 8'h00;
    #1 check("R5 dir only", pad_oe_a, 8'h03);
    bus_write(3'd3, 8'h00);
  endtask

  task automatic t_open_drain;
    bus_write(3'd1, 8'h55);
    bus_write(3'd3, 8'hFF);
    bus_write(3'd4, 8'hFF);
    #1 check("R6 od oe", pad_oe_a, 8'hAA);
    check("R6 od level", pad_out_a, 8'h00);
    bus_write(3'd4, 8'h0F);
    #1 check("R6 mixed oe", pad_oe_a, 8'hFA);
    check("R6 mixed level", pad_out_a, 8'h50);
    bus_write(3'd4, 8'h00);
    bus_write(3'd3, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] a, b;
    @(negedge clk) pad_in = 8'h96;
    bus_read(3'd0, a, b);
    check("R8 one edge old", a, 8'h00);
    bus_read(3'd0, a, b);
    check("R8 two edges new", a, 8'h96);
  endtask

  task automatic t_small;
    logic [7:0] a, b;
    bus_write(3'd2, 8'hFF);
    bus_read(3'd2, a, b);
    check("R9 no mode reg", b, 8'h00);
    bus_write(3'd3, 8'hFF);
    bus_read(3'd3, a, b);
    check("R9 dir low bits", b, 8'h07);
    check("R9 dir pad_oe", pad_oe_b, 8'h07);
    bus_write(3'd1, 8'h12);
    latch_addr(8'hFF);
    #1 check("R9 mcu io only", pad_out_b, 8'h12);
    bus_write(3'd2, 8'h00);
    bus_write(3'd3, 8'h00);
  endtask

  task automatic t_ignore;
    logic [7:0] a, b;
    bus_write(3'd1, 8'h3C);
    bus_write(3'd0, 8'hFF);
    bus_write(3'd5, 8'hFF);
    bus_read(3'd1, a, b);
    check("R10 out unchanged", a, 8'h3C);
    bus_read(3'd3, a, b);
    check("R10 dir unchanged", a, 8'h00);
    bus_read(3'd0, a, b);
    check("R10 pin reg unchanged", a, 8'h96);
    for (int o = 5; o <= 7; o++) begin
      bus_read(3'(o), a, b);
      check("R10 unused reads 0", a, 8'h00);
    end
    @(negedge clk) reg_addr = 3'd1;
    #1 check("R10 idle rdata", rdata_a, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_timing();
    t_mode();
    t_ext_oe();
    t_open_drain();
    t_sync();
    t_small();
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule